// File: doc/BRIEF.md
# Segmented Address Generator with Pointer Carryover

This block turns an 8-bit segment and an 8-bit offset into a 16-bit memory address, and in the same step computes the next value of the instruction pointer or the stack pointer. The access kind picks the segment. Code fetches read through the code segment. Data accesses read through the data segment, and stack accesses through the stack segment. An override bit swaps the extra segment in for data and stack accesses. Each request also yields a second address, one byte above the first, for 16-bit transfers.

Each pointer has its own segment and its own carry enable: the IP is paired with CS, and the SP with SS. When the enable is set, a step or a signed relative move that crosses the top or the bottom of the 256-byte window also moves the paired segment by one. Together the two registers then act as one 16-bit pointer. When the enable is clear, the pointer wraps inside its segment.

Requests arrive on a valid/ready channel and results leave on a second one, through a one-entry output register. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. The result is then offered on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the result stays frozen and no new request is accepted. If the output is taken in the same cycle, a new request can be accepted, so the block runs at full rate.

Top module: `sag_top`

## Requirements
- R1: A fetch (`req_kind`=2'b00) forms `rsp_addr0` = {CS, IP}, that is, segment*256 + offset.
- R2: A data access (`req_kind`=2'b01, or 2'b11) uses DS with offset `req_doff`. It uses ES instead when `req_xseg`=1.
- R3: A stack access (`req_kind`=2'b10) uses SS with offset SP. It uses ES instead when `req_xseg`=1.
- R4: A fetch ignores `req_xseg` and always uses CS.
- R5: `rsp_addr1` is `rsp_addr0`'s offset plus one in the same segment. When the offset is 8'hFF, the new offset is 0. The segment then goes up by one only for a fetch with `req_ip_cy`=1 or a stack access with `req_sp_cy`=1; otherwise it stays.
- R6: `req_tgt`=0 updates the IP/CS pair and `req_tgt`=1 the SP/SS pair. The `req_op` codes are: 0 hold, 1 add 1, 2 add 2, 3 subtract 1, 4 subtract 2, 5 add signed `req_rel`, 6 and 7 hold. The new pointer is `rsp_ptr` and the new paired segment is `rsp_seg`.
- R7: With the target pair's carry enable set, a result above 255 increments the paired segment, and a result below 0 decrements it. Both wrap modulo 256.
- R8: With the target pair's carry enable clear, the pointer wraps modulo 256 and `rsp_seg` equals the unchanged paired segment.
- R9: Op 5 treats `req_rel` as two's complement: 50 plus 8'hF6 gives 40.
- R10: Only the target pair's own enable matters: `req_sp_cy` has no effect on an IP update, and `req_ip_cy` none on an SP update.
- R11: `req_ready` is high whenever the output register is empty or is being taken. While `rsp_valid`=1 and `rsp_ready`=0, all result outputs hold.
- R12: While `rst_n` is low, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 2 | Access kind: 00 fetch, 01 data, 10 stack, 11 data |
| req_xseg | input | 1 | Extra-segment override for data and stack accesses |
| req_tgt | input | 1 | Pointer pair to update: 0 IP/CS, 1 SP/SS |
| req_op | input | 3 | Pointer operation code |
| req_rel | input | 8 | Signed relative amount |
| req_ip_cy | input | 1 | Carry enable for the IP/CS pair |
| req_sp_cy | input | 1 | Carry enable for the SP/SS pair |
| req_cs | input | 8 | Code segment |
| req_ds | input | 8 | Data segment |
| req_es | input | 8 | Extra segment |
| req_ss | input | 8 | Stack segment |
| req_ip | input | 8 | Instruction pointer |
| req_sp | input | 8 | Stack pointer |
| req_doff | input | 8 | Data access offset |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken by the consumer |
| rsp_addr0 | output | 16 | Physical address of the first byte |
| rsp_addr1 | output | 16 | Physical address of the second byte |
| rsp_ptr | output | 8 | Updated pointer value |
| rsp_seg | output | 8 | Updated paired segment value |

## Verification
Directed requests pair each access kind with the override bit both clear and set. This shows which of the four segments reaches the upper address byte, and that fetches ignore the override. Offsets of 8'hFF, and pointer steps that land just past 255 or just below 0, are tried with each carry enable on and off. These show where the segment moves, where it must stay put, and that an enable only acts on its own pair. A long run of pseudo-random requests against a randomly stalling consumer covers the relative-move sign handling, the reserved op codes and the hold behaviour under back-pressure.

// File: rtl/sag_pkg.sv
package sag_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_DATA  = 2'b01,
    ACC_STACK = 2'b10,
    ACC_DATA2 = 2'b11
  } acc_kind_e;

  typedef enum logic [2:0] {
    PST_HOLD = 3'd0,
    PST_INC1 = 3'd1,
    PST_INC2 = 3'd2,
    PST_DEC1 = 3'd3,
    PST_DEC2 = 3'd4,
    PST_REL  = 3'd5,
    PST_RSV6 = 3'd6,
    PST_RSV7 = 3'd7
  } ptr_step_e;

endpackage

// File: rtl/sag_seg_select.sv
module sag_seg_select
  import sag_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFF_W = 8
) (
  input  acc_kind_e           kind,
  input  logic                xseg,
  input  logic [SEG_W-1:0]    cs,
  input  logic [SEG_W-1:0]    ds,
  input  logic [SEG_W-1:0]    es,
  input  logic [SEG_W-1:0]    ss,
  input  logic [OFF_W-1:0]    ip,
  input  logic [OFF_W-1:0]    sp,
  input  logic [OFF_W-1:0]    doff,
  input  logic                ip_cy,
  input  logic                sp_cy,
  output logic [SEG_W-1:0]    seg,
  output logic [OFF_W-1:0]    off,
  output logic                cy_en
);

  always_comb begin
    unique case (kind)
      ACC_FETCH: begin
        seg   = cs;
        off   = ip;
        cy_en = ip_cy;
      end
      ACC_STACK: begin
        seg   = xseg ? es : ss;
        off   = sp;
        cy_en = sp_cy;
      end
      default: begin
        seg   = xseg ? es : ds;
        off   = doff;
        cy_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sag_carry_add.sv
module sag_carry_add #(
  parameter int SEG_W = 8,
  parameter int OFF_W = 8
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W-1:0] delta,
  input  logic             cy_en,
  output logic [SEG_W-1:0] seg_o,
  output logic [OFF_W-1:0] off_o
);

  localparam int SUM_W = OFF_W + 2;

  logic [SUM_W-1:0] sum;
  logic [1:0]       excess;

  always_comb begin
    sum    = {2'b00, off} + {{2{delta[OFF_W-1]}}, delta};
    excess = sum[SUM_W-1:OFF_W];
    off_o  = sum[OFF_W-1:0];
    seg_o  = seg;
    if (cy_en) begin
      unique case (excess)
        2'b01:   seg_o = seg + SEG_W'(1);
        2'b11:   seg_o = seg - SEG_W'(1);
        default: seg_o = seg;
      endcase
    end
  end

endmodule

// File: rtl/sag_out_reg.sv
module sag_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= in_data;
    end
  end

endmodule

// File: rtl/sag_top.sv
module sag_top
  import sag_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFF_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic                     req_xseg,
  input  logic                     req_tgt,
  input  logic [2:0]               req_op,
  input  logic [OFF_W-1:0]         req_rel,
  input  logic                     req_ip_cy,
  input  logic                     req_sp_cy,
  input  logic [SEG_W-1:0]         req_cs,
  input  logic [SEG_W-1:0]         req_ds,
  input  logic [SEG_W-1:0]         req_es,
  input  logic [SEG_W-1:0]         req_ss,
  input  logic [OFF_W-1:0]         req_ip,
  input  logic [OFF_W-1:0]         req_sp,
  input  logic [OFF_W-1:0]         req_doff,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [SEG_W+OFF_W-1:0]   rsp_addr0,
  output logic [SEG_W+OFF_W-1:0]   rsp_addr1,
  output logic [OFF_W-1:0]         rsp_ptr,
  output logic [SEG_W-1:0]         rsp_seg
);

  localparam int ADDR_W = SEG_W + OFF_W;
  localparam int RES_W  = 2 * ADDR_W + OFF_W + SEG_W;

  // access segment and offset
  logic [SEG_W-1:0] acc_seg;
  logic [OFF_W-1:0] acc_off;
  logic             acc_cy;

  sag_seg_select #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_sel (
    .kind  (acc_kind_e'(req_kind)),
    .xseg  (req_xseg),
    .cs    (req_cs),
    .ds    (req_ds),
    .es    (req_es),
    .ss    (req_ss),
    .ip    (req_ip),
    .sp    (req_sp),
    .doff  (req_doff),
    .ip_cy (req_ip_cy),
    .sp_cy (req_sp_cy),
    .seg   (acc_seg),
    .off   (acc_off),
    .cy_en (acc_cy)
  );

  // second byte of a 16-bit transfer
  logic [SEG_W-1:0] nxt_seg;
  logic [OFF_W-1:0] nxt_off;

  sag_carry_add #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_next (
    .seg   (acc_seg),
    .off   (acc_off),
    .delta (OFF_W'(1)),
    .cy_en (acc_cy),
    .seg_o (nxt_seg),
    .off_o (nxt_off)
  );

  // pointer update on the chosen pair
  logic [SEG_W-1:0] pr_seg;
  logic [OFF_W-1:0] pr_ptr;
  logic             pr_cy;
  logic [OFF_W-1:0] step;

  always_comb begin
    pr_seg = req_tgt ? req_ss    : req_cs;
    pr_ptr = req_tgt ? req_sp    : req_ip;
    pr_cy  = req_tgt ? req_sp_cy : req_ip_cy;
  end

  always_comb begin
    unique case (ptr_step_e'(req_op))
      PST_INC1: step = OFF_W'(1);
      PST_INC2: step = OFF_W'(2);
      PST_DEC1: step = {OFF_W{1'b1}};
      PST_DEC2: step = ~OFF_W'(1);
      PST_REL:  step = req_rel;
      default:  step = '0;
    endcase
  end

  logic [SEG_W-1:0] upd_seg;
  logic [OFF_W-1:0] upd_ptr;

  sag_carry_add #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_ptr (
    .seg   (pr_seg),
    .off   (pr_ptr),
    .delta (step),
    .cy_en (pr_cy),
    .seg_o (upd_seg),
    .off_o (upd_ptr)
  );

  // output stage
  logic [RES_W-1:0] res_in;
  logic [RES_W-1:0] res_out;

  assign res_in = {acc_seg, acc_off, nxt_seg, nxt_off, upd_ptr, upd_seg};

  sag_out_reg #(.W(RES_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (res_in),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (res_out)
  );

  assign {rsp_addr0, rsp_addr1, rsp_ptr, rsp_seg} = res_out;

endmodule

// File: rtl/sag_top_chk.sv
module sag_top_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr0,
  input logic [ADDR_W-1:0] rsp_addr1
);

  a_r12_reset_idle: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr0) && $stable(rsp_addr1));

  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r11_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  a_r5_next_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_addr0[OFF_W-1:0] != {OFF_W{1'b1}}) |-> rsp_addr1 == rsp_addr0 + ADDR_W'(1));

  a_r5_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_addr0[OFF_W-1:0] == {OFF_W{1'b1}}) |-> rsp_addr1[OFF_W-1:0] == '0);

endmodule

bind sag_top sag_top_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr0 (rsp_addr0),
  .rsp_addr1 (rsp_addr1)
);

// File: tb/sag_top_tb_top.sv
module sag_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic        req_xseg = 1'b0, req_tgt = 1'b0;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_rel = '0;
  logic        req_ip_cy = 1'b0, req_sp_cy = 1'b0;
  logic [7:0]  req_cs = '0, req_ds = '0, req_es = '0, req_ss = '0;
  logic [7:0]  req_ip = '0, req_sp = '0, req_doff = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_addr0, rsp_addr1;
  logic [7:0]  rsp_ptr, rsp_seg;

  sag_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_xseg(req_xseg), .req_tgt(req_tgt), .req_op(req_op),
    .req_rel(req_rel), .req_ip_cy(req_ip_cy), .req_sp_cy(req_sp_cy),
    .req_cs(req_cs), .req_ds(req_ds), .req_es(req_es), .req_ss(req_ss),
    .req_ip(req_ip), .req_sp(req_sp), .req_doff(req_doff),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr0(rsp_addr0),
    .rsp_addr1(rsp_addr1), .rsp_ptr(rsp_ptr), .rsp_seg(rsp_seg)
  );

  typedef struct {
    logic [15:0] a0;
    logic [15:0] a1;
    logic [7:0]  p;
    logic [7:0]  s;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad   = 0;
  bit stall_mode = 1'b0;
  bit done_drv = 1'b0;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference computed from the requirement text
  function automatic exp_t model(int kind, int xs, int tgt, int op, int rel,
                                 int ipc, int spc, int cs, int ds, int es, int ss,
                                 int ip, int sp, int doff, string tag);
    exp_t e;
    int seg, off, cyok, d, p, s, c, sum;
    if (kind == 0) begin seg = cs; off = ip; cyok = ipc; end
    else if (kind == 2) begin seg = xs ? es : ss; off = sp; cyok = spc; end
    else begin seg = xs ? es : ds; off = doff; cyok = 0; end
    e.a0 = 16'(seg * 256 + off);
    if (off == 255) e.a1 = 16'(((cyok != 0) ? ((seg + 1) % 256) : seg) * 256);
    else            e.a1 = 16'(seg * 256 + off + 1);
    p = tgt ? sp : ip;
    s = tgt ? ss : cs;
    c = tgt ? spc : ipc;
    case (op)
      1: d = 1;
      2: d = 2;
      3: d = -1;
      4: d = -2;
      5: d = (rel >= 128) ? rel - 256 : rel;
      default: d = 0;
    endcase
    sum = p + d;
    if (c != 0 && sum > 255) s = (s + 1) % 256;
    if (c != 0 && sum < 0)   s = (s + 255) % 256;
    e.p = 8'((sum + 256) % 256);
    e.s = 8'(s);
    e.tag = tag;
    return e;
  endfunction

  task automatic send(int kind, int xs, int tgt, int op, int rel, int ipc, int spc,
                      int cs, int ds, int es, int ss, int ip, int sp, int doff,
                      string tag);
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk);
      #2;
      req_valid = 1'b1;
      req_kind = 2'(kind); req_xseg = 1'(xs); req_tgt = 1'(tgt); req_op = 3'(op);
      req_rel = 8'(rel); req_ip_cy = 1'(ipc); req_sp_cy = 1'(spc);
      req_cs = 8'(cs); req_ds = 8'(ds); req_es = 8'(es); req_ss = 8'(ss);
      req_ip = 8'(ip); req_sp = 8'(sp); req_doff = 8'(doff);
      if (req_ready) begin
        exp_q.push_back(model(kind, xs, tgt, op, rel, ipc, spc, cs, ds, es, ss,
                              ip, sp, doff, tag));
        done = 1'b1;
      end
    end
    @(negedge clk);
    #2;
    req_valid = 1'b0;
  endtask

  // monitor: consumer with random stalls, pops and compares
  initial begin
    bit          held = 1'b0;
    logic [15:0] h0, h1;
    logic [7:0]  hp, hs;
    exp_t        e;
    forever begin
      @(negedge clk);
      #1;
      rsp_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
      #2;
      if (held) begin
        total++;
        if (!(rsp_valid && rsp_addr0 == h0 && rsp_addr1 == h1 && rsp_ptr == hp && rsp_seg == hs)) begin
          bad++;
          $display("FAIL R11 hold: got v=%0b %h %h %h %h exp v=1 %h %h %h %h",
                   rsp_valid, rsp_addr0, rsp_addr1, rsp_ptr, rsp_seg, h0, h1, hp, hs);
        end
      end
      held = rst_n && rsp_valid && !rsp_ready;
      h0 = rsp_addr0; h1 = rsp_addr1; hp = rsp_ptr; hs = rsp_seg;
      if (rst_n && rsp_valid && rsp_ready) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R11 unexpected result: got a0=%h exp none", rsp_addr0);
        end else begin
          e = exp_q.pop_front();
          if (rsp_addr0 !== e.a0 || rsp_addr1 !== e.a1 || rsp_ptr !== e.p || rsp_seg !== e.s) begin
            bad++;
            $display("FAIL %s: got a0=%h a1=%h ptr=%h seg=%h exp a0=%h a1=%h ptr=%h seg=%h",
                     e.tag, rsp_addr0, rsp_addr1, rsp_ptr, rsp_seg, e.a0, e.a1, e.p, e.s);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R11 watchdog: outstanding=%0d exp 0", exp_q.size());
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    total++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      bad++;
      $display("FAIL R12 reset: got valid=%0b ready=%0b exp valid=0 ready=1", rsp_valid, req_ready);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // kind, xs, tgt, op, rel, ipc, spc, cs, ds, es, ss, ip, sp, doff
    send(0, 0, 0, 0, 0, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h10, 8'h07, "R1");
    send(1, 0, 0, 0, 0, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h10, 8'h07, "R2");
    send(1, 1, 0, 0, 0, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h10, 8'h07, "R2");
    send(3, 1, 0, 0, 0, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h10, 8'h09, "R2");
    send(2, 0, 1, 0, 0, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h10, 8'h07, "R3");
    send(2, 1, 1, 0, 0, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h10, 8'h07, "R3");
    send(0, 1, 0, 0, 0, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h10, 8'h07, "R4");
    send(0, 0, 0, 0, 0, 1, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'hFF, 8'h10, 8'h07, "R5");
    send(0, 0, 0, 0, 0, 0, 1, 8'h12, 8'h40, 8'h50, 8'h60, 8'hFF, 8'h10, 8'h07, "R5");
    send(1, 0, 0, 0, 0, 1, 1, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h10, 8'hFF, "R5");
    send(2, 0, 1, 0, 0, 0, 1, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'hFF, 8'h07, "R5");
    send(0, 0, 0, 1, 0, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h10, 8'h07, "R6");
    send(0, 0, 1, 3, 0, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h10, 8'h07, "R6");
    send(0, 0, 1, 6, 0, 1, 1, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'hFF, 8'h07, "R6");
    send(0, 0, 0, 1, 0, 1, 0, 8'hFF, 8'h40, 8'h50, 8'h60, 8'hFF, 8'h10, 8'h07, "R7");
    send(2, 0, 1, 4, 0, 0, 1, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h01, 8'h07, "R7");
    send(0, 0, 0, 2, 0, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'hFF, 8'h10, 8'h07, "R8");
    send(0, 0, 1, 3, 0, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'h00, 8'h07, "R8");
    send(0, 0, 0, 5, 8'hF6, 0, 0, 8'h12, 8'h40, 8'h50, 8'h60, 50, 8'h10, 8'h07, "R9");
    send(0, 0, 0, 5, 8'hEC, 1, 0, 8'h12, 8'h40, 8'h50, 8'h60, 10, 8'h10, 8'h07, "R9");
    send(0, 0, 1, 5, 127, 0, 1, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 200, 8'h07, "R9");
    send(0, 0, 0, 1, 0, 0, 1, 8'h12, 8'h40, 8'h50, 8'h60, 8'hFF, 8'h10, 8'h07, "R10");
    send(0, 0, 1, 2, 0, 1, 0, 8'h12, 8'h40, 8'h50, 8'h60, 8'h34, 8'hFF, 8'h07, "R10");

    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send($urandom % 4, $urandom % 2, $urandom % 2, $urandom % 8, $urandom % 256,
           $urandom % 2, $urandom % 2, $urandom % 256, $urandom % 256, $urandom % 256,
           $urandom % 256, (i % 5 == 0) ? 255 : $urandom % 256,
           (i % 7 == 0) ? 0 : $urandom % 256, $urandom % 256, "R11");
    end
    stall_mode = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done_drv = 1'b1;
    summary();
  end

endmodule